// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block forms the address of one operand access in a machine with 16-bit segments. A requester presents an addressing mode, a 16-bit displacement (or a direct address), the current pointer register values (BX, SI, DI), the instruction pointer, the three segment registers (CS, DS, ES) and a segment-override select. In return the block gives a 16-bit effective offset and a 20-bit physical address. The physical address is the segment value multiplied by sixteen plus the offset.

The results are registered and appear one clock after the request, together with a one-cycle valid strobe. One mode forms the instruction-fetch address from CS and IP. The immediate and register operand modes have no memory address. For those modes the block raises a no-memory flag instead.

Top module: `seg_addr_gen`

## Requirements
- R1: `addrValid` is high in the cycle after a cycle with `reqValid` high. It is low in the cycle after a cycle with `reqValid` low.
- R2: Mode 2 (direct) gives an effective offset equal to `disp`.
- R3: Mode 3 (register indirect) gives an effective offset equal to the selected pointer. `ptrSel` 0 selects BX, 1 selects SI, 2 selects DI and 3 selects BX.
- R4: Mode 4 (pointer plus displacement) gives an offset equal to the selected pointer plus `disp`, modulo 2^16.
- R5: Mode 5 (base plus index plus displacement) gives an offset equal to BX plus an index plus `disp`, modulo 2^16. The index is DI when `ptrSel` is 2 and SI otherwise.
- R6: For every memory mode, `physAddr` equals segment*16 + offset, modulo 2^20. The offset is wrapped to 16 bits before the segment is added.
- R7: For data modes, `segOvr` 0 selects DS (the default), 1 selects ES, 2 selects CS and 3 selects DS.
- R8: Mode 6 (instruction fetch) gives offset IP and segment CS, whatever the values of `segOvr`, `disp` and `ptrSel`.
- R9: Modes 0 (immediate), 1 (register) and 7 (unused) set `noMem` to 1 and give an offset and physical address of 0. Modes 2 to 6 set `noMem` to 0.
- R10: During reset and after it, `addrValid`, `noMem`, `effOffset` and `physAddr` are all 0.
- R11: When no request is made, `effOffset`, `physAddr` and `noMem` keep the values of the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| disp | input | 16 | Displacement or direct address |
| ptrSel | input | 2 | Pointer and index select |
| segOvr | input | 2 | Segment override select |
| regBx | input | 16 | BX value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| regIp | input | 16 | Instruction pointer value |
| segCs | input | 16 | Code segment value |
| segDs | input | 16 | Data segment value |
| segEs | input | 16 | Extra segment value |
| addrValid | output | 1 | One-cycle result strobe |
| noMem | output | 1 | Set when the operand needs no memory access |
| effOffset | output | 16 | Effective offset |
| physAddr | output | 20 | Physical address |

## Verification
Every result, including the valid strobe, the offset, the physical address and the no-memory flag, is due exactly one clock edge after the request. The bench drives each request on a falling edge and takes it away on the next falling edge. It then samples all outputs at that same falling edge, which lies half a period after the only register stage. One further falling edge later it checks that valid has dropped and that the other outputs still hold the values of that request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [2:0] {
    MD_IMM    = 3'd0,
    MD_REG    = 3'd1,
    MD_DIRECT = 3'd2,
    MD_INDIR  = 3'd3,
    MD_PTRDSP = 3'd4,
    MD_BIXDSP = 3'd5,
    MD_FETCH  = 3'd6,
    MD_UNUSED = 3'd7
  } addrMode_e;

  typedef enum logic [1:0] {
    SO_DEFAULT = 2'd0,
    SO_ES      = 2'd1,
    SO_CS      = 2'd2,
    SO_DS      = 2'd3
  } segOvr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic fetch;
    logic useBx;
    logic usePtr;
    logic useIdx;
    logic addDisp;
    logic noMem;
  } addrStrb_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [2:0] mode,
  output addrStrb_t strb,
  output logic      addrValid,
  output logic      noMem
);
  always_comb begin
    strb      = '0;
    strb.load = reqValid;
    case (addrMode_e'(mode))
      MD_DIRECT: strb.addDisp = 1'b1;
      MD_INDIR:  strb.usePtr  = 1'b1;
      MD_PTRDSP: begin
        strb.usePtr  = 1'b1;
        strb.addDisp = 1'b1;
      end
      MD_BIXDSP: begin
        strb.useBx   = 1'b1;
        strb.useIdx  = 1'b1;
        strb.addDisp = 1'b1;
      end
      MD_FETCH:  strb.fetch   = 1'b1;
      default:   strb.noMem   = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      noMem     <= 1'b0;
    end else begin
      addrValid <= reqValid;
      if (reqValid) noMem <= strb.noMem;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid); // R1
  AST_NOMEM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (mode == 3'd0 || mode == 3'd1)) |=> noMem); // R9
  AST_MEM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode >= 3'd2 && mode <= 3'd6) |=> !noMem); // R9
endmodule

// File: rtl/seg_addr_datapath.sv
module seg_addr_datapath
  import seg_addr_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFF_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrStrb_t         strb,
  input  logic [OFF_W-1:0]  disp,
  input  logic [1:0]        ptrSel,
  input  logic [1:0]        segOvr,
  input  logic [OFF_W-1:0]  regBx,
  input  logic [OFF_W-1:0]  regSi,
  input  logic [OFF_W-1:0]  regDi,
  input  logic [OFF_W-1:0]  regIp,
  input  logic [OFF_W-1:0]  segCs,
  input  logic [OFF_W-1:0]  segDs,
  input  logic [OFF_W-1:0]  segEs,
  output logic [OFF_W-1:0]  effOffset,
  output logic [PHYS_W-1:0] physAddr
);
  logic [OFF_W-1:0]  ptrVal, idxVal, opA, opB, opD, offSum, segVal;
  logic [PHYS_W-1:0] physSum;

  always_comb begin
    case (ptrSel)
      2'd1:    ptrVal = regSi;
      2'd2:    ptrVal = regDi;
      default: ptrVal = regBx;
    endcase
    idxVal = (ptrSel == 2'd2) ? regDi : regSi;
  end

  always_comb begin
    if (strb.fetch)       opA = regIp;
    else if (strb.useBx)  opA = regBx;
    else if (strb.usePtr) opA = ptrVal;
    else                  opA = '0;
    opB    = strb.useIdx  ? idxVal : '0;
    opD    = strb.addDisp ? disp   : '0;
    offSum = opA + opB + opD;
  end

  always_comb begin
    if (strb.fetch) segVal = segCs;
    else begin
      case (segOvr_e'(segOvr))
        SO_ES:   segVal = segEs;
        SO_CS:   segVal = segCs;
        default: segVal = segDs;
      endcase
    end
    physSum = {segVal, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offSum};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effOffset <= '0;
      physAddr  <= '0;
    end else if (strb.load) begin
      effOffset <= strb.noMem ? '0 : offSum;
      physAddr  <= strb.noMem ? '0 : physSum;
    end
  end

  AST_FETCH_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.fetch) |=> effOffset == $past(regIp)); // R8
  AST_NOMEM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.noMem) |=> (physAddr == '0 && effOffset == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(physAddr) && $stable(effOffset))); // R11
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  mode,
  input  logic [15:0] disp,
  input  logic [1:0]  ptrSel,
  input  logic [1:0]  segOvr,
  input  logic [15:0] regBx,
  input  logic [15:0] regSi,
  input  logic [15:0] regDi,
  input  logic [15:0] regIp,
  input  logic [15:0] segCs,
  input  logic [15:0] segDs,
  input  logic [15:0] segEs,
  output logic        addrValid,
  output logic        noMem,
  output logic [15:0] effOffset,
  output logic [19:0] physAddr
);
  addrStrb_t strb;

  seg_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .strb(strb), .addrValid(addrValid), .noMem(noMem)
  );

  seg_addr_datapath #(.OFF_W(16), .SEG_SHIFT(4)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .disp(disp), .ptrSel(ptrSel),
    .segOvr(segOvr), .regBx(regBx), .regSi(regSi), .regDi(regDi),
    .regIp(regIp), .segCs(segCs), .segDs(segDs), .segEs(segEs),
    .effOffset(effOffset), .physAddr(physAddr)
  );

  AST_DIRECT_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd2) |=> effOffset == $past(disp)); // R2
  AST_DEFAULT_SEG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd2 && segOvr == 2'd0)
      |=> physAddr == ({$past(segDs), 4'h0} + {4'h0, $past(disp)})); // R7
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] disp = '0;
  logic [1:0]  ptrSel = '0;
  logic [1:0]  segOvr = '0;
  logic [15:0] regBx = '0, regSi = '0, regDi = '0, regIp = '0;
  logic [15:0] segCs = '0, segDs = '0, segEs = '0;
  logic        addrValid, noMem;
  logic [15:0] effOffset;
  logic [19:0] physAddr;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .disp(disp),
    .ptrSel(ptrSel), .segOvr(segOvr), .regBx(regBx), .regSi(regSi),
    .regDi(regDi), .regIp(regIp), .segCs(segCs), .segDs(segDs),
    .segEs(segEs), .addrValid(addrValid), .noMem(noMem),
    .effOffset(effOffset), .physAddr(physAddr)
  );

  function automatic logic [15:0] expOff(input logic [2:0] m);
    logic [15:0] p, ix;
    p  = (ptrSel == 2'd1) ? regSi : (ptrSel == 2'd2) ? regDi : regBx;
    ix = (ptrSel == 2'd2) ? regDi : regSi;
    case (m)
      3'd2: return disp;                       // R2
      3'd3: return p;                          // R3
      3'd4: return p + disp;                   // R4
      3'd5: return regBx + ix + disp;          // R5
      3'd6: return regIp;                      // R8
      default: return 16'h0;                   // R9
    endcase
  endfunction

  function automatic logic [19:0] expPhys(input logic [2:0] m);
    logic [15:0] s;
    if (m < 3'd2 || m == 3'd7) return 20'h0;
    if (m == 3'd6) s = segCs;
    else s = (segOvr == 2'd1) ? segEs : (segOvr == 2'd2) ? segCs : segDs; // R7
    return ({s, 4'h0} + {4'h0, expOff(m)});    // R6
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h (mode=%0d)", req, act, exp, mode);
    end
  endtask

  task automatic request(input logic [2:0] m);
    logic [15:0] eo;
    logic [19:0] ep;
    logic en;
    mode = m;
    eo = expOff(m);
    ep = expPhys(m);
    en = (m < 3'd2 || m == 3'd7);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 valid", 32'(addrValid), 32'd1);
    check("R9 noMem", 32'(noMem), 32'(en));
    check("R2-R5,R8 offset", 32'(effOffset), 32'(eo));
    check("R6 phys", 32'(physAddr), 32'(ep));
    // change inputs while idle: outputs must hold (R11)
    disp = disp ^ 16'h5a5a;
    regBx = regBx + 16'd3;
    @(negedge clk);
    check("R1 valid drop", 32'(addrValid), 32'd0);
    check("R11 hold offset", 32'(effOffset), 32'(eo));
    check("R11 hold phys", 32'(physAddr), 32'(ep));
  endtask

  task automatic randInputs();
    disp = 16'($urandom); regBx = 16'($urandom); regSi = 16'($urandom);
    regDi = 16'($urandom); regIp = 16'($urandom); segCs = 16'($urandom);
    segDs = 16'($urandom); segEs = 16'($urandom);
    ptrSel = 2'($urandom); segOvr = 2'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", 32'(addrValid), 32'd0);
    check("R10 noMem", 32'(noMem), 32'd0);
    check("R10 offset", 32'(effOffset), 32'd0);
    check("R10 phys", 32'(physAddr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after reset", 32'(addrValid), 32'd0);

    // directed: R3 pointer selections
    regBx = 16'h1111; regSi = 16'h2222; regDi = 16'h3333; segDs = 16'h1000;
    for (int k = 0; k < 4; k++) begin
      ptrSel = 2'(k); segOvr = 2'd0;
      request(3'd3);
    end
    // R4/R5 offset wrap
    regBx = 16'hFFFF; regSi = 16'h0002; regDi = 16'h8000; disp = 16'h0001;
    ptrSel = 2'd0; request(3'd4);
    ptrSel = 2'd1; request(3'd5);
    ptrSel = 2'd2; request(3'd5);
    // R6 physical wrap: FFFF:FFFF -> 0FFEF
    segDs = 16'hFFFF; disp = 16'hFFFF; segOvr = 2'd0;
    request(3'd2);
    check("R6 wrap value", 32'(physAddr), 32'h0FFEF);
    // R7 each override
    segCs = 16'hA000; segDs = 16'hB000; segEs = 16'hC000; disp = 16'h0010;
    for (int k = 0; k < 4; k++) begin
      segOvr = 2'(k);
      request(3'd2);
    end
    // R8 fetch ignores override
    regIp = 16'h0100; segOvr = 2'd1; request(3'd6);
    check("R8 fetch phys", 32'(physAddr), 32'hA0100);
    // R9 no-memory modes
    request(3'd0); request(3'd1); request(3'd7);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      randInputs();
      request(3'($urandom));
    end

    // back-to-back requests: R1 valid stays high
    randInputs(); mode = 3'd4; reqValid = 1'b1;
    @(negedge clk);
    check("R1 back-to-back first", 32'(physAddr), 32'(expPhys(3'd4)));
    mode = 3'd5;
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 back-to-back valid", 32'(addrValid), 32'd1);
    check("R5 back-to-back offset", 32'(effOffset), 32'(expOff(3'd5)));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule